// File: doc/BRIEF.md
# Change-Triggered Pixel Exposure Sequencer

This block is the synchronous control logic of a single frame-free vision pixel. A temporal-change detector gives it two comparator flags, one for a rise and one for a fall in log intensity. An exposure integrator gives it two threshold flags. The block never scans and never runs on a frame timer. Only a detected change produces output. Each change is sent as an event with a polarity bit. That change then arms a fresh exposure measurement, which is reported as two events. Gray level is carried by the time between those two events, so brighter light gives a shorter gap.

All events leave through one request/acknowledge port that feeds a shared address-event bus. Each event word carries the pixel's fixed column and row address and one low bit. The `evt_exp` class line says how to read that bit. For the second exposure event the port also presents the measured interval in clock cycles and a saturation flag. Change events and exposure events wait in separate one-deep holding registers. A pending change event always wins the port, and no event is ever lost.

Top module: `pix_evt_seq`

## Requirements
- R1: After synchronous reset, `req`, `cd_rst`, `exp_run`, `evt_exp`, `evt_ovf` and `evt_word` are all zero.
- R2: When `chg_up` or `chg_dn` is high and no change event is held, a change event is issued with `evt_exp`=0. Word bit 0 is 1 for `chg_up` and 0 for `chg_dn`.
- R3: `cd_rst` rises in the cycle after a change is captured and stays high until that event is acknowledged. While `cd_rst` is high, the comparator flags create no further change event.
- R4: Threshold flags that are not preceded by a change event produce no event at all.
- R5: A measurement starts only after a change event has been acknowledged, and `exp_run` is high while it runs. The first threshold gives an exposure event with bit 0 = 0. The second gives one with bit 0 = 1, whose `evt_ival` equals the number of clock edges between the edge that sampled the first threshold and the edge that sampled the second.
- R6: If `evt_ival` would reach 2^CNT_W-1 before the second threshold, the measurement ends with `evt_ival` = 2^CNT_W-1 and `evt_ovf` = 1. A second threshold sampled exactly at that count gives the same interval with `evt_ovf` = 0.
- R7: A change captured while a measurement is running aborts it. The aborted measurement produces no second event, and a new measurement starts once the new change event is acknowledged.
- R8: `req` rises with the word, class, interval and flag set up. These stay stable while `req` is high and `ack` is low. `req` falls in the cycle after `ack` is sampled high, and a new request starts only after `ack` has been sampled low.
- R9: When a change event and an exposure event are both held while the port is idle, the change event goes first. A finished interval waiting for the exposure register is still delivered later.
- R10: The event word carries the column address in bits [X_W+Y_W:Y_W+1], the row address in bits [Y_W:1] and the polarity/order bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_up | input | 1 | Change comparator flag, intensity rose |
| chg_dn | input | 1 | Change comparator flag, intensity fell |
| thr1 | input | 1 | Integrator crossed the first threshold |
| thr2 | input | 1 | Integrator crossed the second threshold |
| ack | input | 1 | Bus acknowledge |
| req | output | 1 | Bus request |
| evt_word | output | X_W+Y_W+1 (18) | Column, row, polarity/order bit |
| evt_exp | output | 1 | 1 = exposure event, 0 = change event |
| evt_ival | output | CNT_W (16) | Interval in cycles, valid on the second exposure event |
| evt_ovf | output | 1 | Interval saturated |
| cd_rst | output | 1 | Holds the change detector in reset |
| exp_run | output | 1 | Integrator released, measurement running |

## Verification
The assertions rely on the bus partner raising `ack` only while `req` is high and dropping it only after `req` has fallen. They also assume the two change flags are never high together, and that the threshold flags are high only while `exp_run` is high, with `thr2` never before `thr1`. The bench acknowledge responder follows the four-phase rule with random wait and release delays. The stimulus raises threshold flags only after seeing `exp_run` high, lowers them once it falls, and pulses one change flag at a time. Directed cases cover abort, saturation and priority; randomized trials vary polarity, interval length and acknowledge timing.

// File: rtl/pix_evt_pkg.sv
package pix_evt_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ARM   = 3'd1,
    S_WT1   = 3'd2,
    S_WT2   = 3'd3,
    S_HOLD2 = 3'd4
  } exp_st_t;

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_REQ  = 2'd1,
    P_REL  = 2'd2
  } port_st_t;
endpackage

// File: rtl/pix_chg_catch.sv
module pix_chg_catch (
  input  logic clk,
  input  logic rst,
  input  logic up,
  input  logic dn,
  input  logic hold,
  input  logic pop,
  output logic full,
  output logic pol,
  output logic new_evt
);
  // a crossing is taken only while the holder is empty (detector out of reset)
  assign new_evt = !full && !hold && (up || dn);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      pol  <= 1'b0;
    end else if (pop) begin
      full <= 1'b0;
    end else if (new_evt) begin
      full <= 1'b1;
      pol  <= up;
    end
  end

  assert_chg_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> (full && $stable(pol)));
endmodule

// File: rtl/pix_exp_seq.sv
module pix_exp_seq
  import pix_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr1,
  input  logic             thr2,
  input  logic             chg_new,
  input  logic             chg_pop,
  input  logic             exp_pop,
  output logic             run,
  output logic             hold2,
  output logic             exp_full,
  output logic             exp_second,
  output logic [CNT_W-1:0] exp_ival,
  output logic             exp_ovf
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  exp_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pend_ival;
  logic             pend_ovf;

  logic             push1, fin, push2, push;
  logic             at_max;
  logic [CNT_W-1:0] push_ival;
  logic             push_ovf;

  assign at_max = (cnt == MAXV);
  assign push1  = (st == S_WT1) && thr1 && !exp_full && !chg_new;
  assign fin    = (st == S_WT2) && (thr2 || at_max) && !chg_new;
  assign push2  = (fin && !exp_full) || ((st == S_HOLD2) && !exp_full);
  assign push   = push1 || push2;

  always_comb begin
    if (push1) begin
      push_ival = '0;
      push_ovf  = 1'b0;
    end else if (st == S_HOLD2) begin
      push_ival = pend_ival;
      push_ovf  = pend_ovf;
    end else begin
      push_ival = cnt;
      push_ovf  = at_max && !thr2;
    end
  end

  assign run   = (st == S_WT1) || (st == S_WT2);
  assign hold2 = (st == S_HOLD2);

  // one-deep exposure event holder
  always_ff @(posedge clk) begin
    if (rst) begin
      exp_full   <= 1'b0;
      exp_second <= 1'b0;
      exp_ival   <= '0;
      exp_ovf    <= 1'b0;
    end else if (exp_pop) begin
      exp_full <= 1'b0;
    end else if (push) begin
      exp_full   <= 1'b1;
      exp_second <= !push1;
      exp_ival   <= push_ival;
      exp_ovf    <= push_ovf;
    end
  end

  // measurement sequencer and interval counter
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      pend_ival <= '0;
      pend_ovf  <= 1'b0;
    end else if (chg_new) begin
      st <= S_ARM;
    end else begin
      case (st)
        S_ARM: if (chg_pop) st <= S_WT1;
        S_WT1: if (push1) begin
          cnt <= CNT_W'(1);
          st  <= S_WT2;
        end
        S_WT2: begin
          if (fin) begin
            pend_ival <= cnt;
            pend_ovf  <= at_max && !thr2;
            st        <= exp_full ? S_HOLD2 : S_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_HOLD2: if (!exp_full) st <= S_IDLE;
        default: st <= st;
      endcase
    end
  end

  assert_exp_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (exp_full && !exp_pop) |=> (exp_full && $stable(exp_ival) && $stable(exp_second)));
  assert_start_after_send_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(chg_pop));
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    chg_new |=> (st == S_ARM));
endmodule

// File: rtl/pix_evt_port.sv
module pix_evt_port
  import pix_evt_pkg::*;
#(
  parameter int X_W    = 9,
  parameter int Y_W    = 8,
  parameter int CNT_W  = 16,
  parameter int X_ADDR = 0,
  parameter int Y_ADDR = 0,
  localparam int W     = X_W + Y_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chg_full,
  input  logic             chg_pol,
  input  logic             exp_full,
  input  logic             exp_second,
  input  logic [CNT_W-1:0] exp_ival,
  input  logic             exp_ovf,
  input  logic             ack,
  output logic             req,
  output logic [W-1:0]     evt_word,
  output logic             evt_exp,
  output logic [CNT_W-1:0] evt_ival,
  output logic             evt_ovf,
  output logic             chg_pop,
  output logic             exp_pop
);
  localparam logic [X_W-1:0] XA = X_W'(X_ADDR);
  localparam logic [Y_W-1:0] YA = Y_W'(Y_ADDR);

  port_st_t pst;
  logic     sel_exp;

  assign chg_pop = (pst == P_REQ) && ack && !sel_exp;
  assign exp_pop = (pst == P_REQ) && ack && sel_exp;

  always_ff @(posedge clk) begin
    if (rst) begin
      pst      <= P_IDLE;
      req      <= 1'b0;
      sel_exp  <= 1'b0;
      evt_word <= '0;
      evt_exp  <= 1'b0;
      evt_ival <= '0;
      evt_ovf  <= 1'b0;
    end else begin
      case (pst)
        P_IDLE: begin
          if (chg_full) begin
            evt_word <= {XA, YA, chg_pol};
            evt_exp  <= 1'b0;
            evt_ival <= '0;
            evt_ovf  <= 1'b0;
            sel_exp  <= 1'b0;
            req      <= 1'b1;
            pst      <= P_REQ;
          end else if (exp_full) begin
            evt_word <= {XA, YA, exp_second};
            evt_exp  <= 1'b1;
            evt_ival <= exp_ival;
            evt_ovf  <= exp_ovf;
            sel_exp  <= 1'b1;
            req      <= 1'b1;
            pst      <= P_REQ;
          end
        end
        P_REQ: if (ack) begin
          req <= 1'b0;
          pst <= P_REL;
        end
        P_REL: if (!ack) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(evt_word) && $stable(evt_ival)));
  assert_req_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack));
  assert_chg_first_R9: assert property (@(posedge clk) disable iff (rst)
    ((pst == P_IDLE) && chg_full && exp_full) |=> (req && !evt_exp));
endmodule

// File: rtl/pix_evt_seq.sv
module pix_evt_seq #(
  parameter int X_W    = 9,
  parameter int Y_W    = 8,
  parameter int CNT_W  = 16,
  parameter int X_ADDR = 0,
  parameter int Y_ADDR = 0,
  localparam int W     = X_W + Y_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chg_up,
  input  logic             chg_dn,
  input  logic             thr1,
  input  logic             thr2,
  input  logic             ack,
  output logic             req,
  output logic [W-1:0]     evt_word,
  output logic             evt_exp,
  output logic [CNT_W-1:0] evt_ival,
  output logic             evt_ovf,
  output logic             cd_rst,
  output logic             exp_run
);
  logic             chg_full, chg_pol, chg_new, chg_pop;
  logic             exp_full, exp_second, exp_ovf, exp_pop, hold2;
  logic [CNT_W-1:0] exp_ival;

  pix_chg_catch u_chg (
    .clk(clk), .rst(rst), .up(chg_up), .dn(chg_dn), .hold(hold2),
    .pop(chg_pop), .full(chg_full), .pol(chg_pol), .new_evt(chg_new)
  );

  pix_exp_seq #(.CNT_W(CNT_W)) u_exp (
    .clk(clk), .rst(rst), .thr1(thr1), .thr2(thr2), .chg_new(chg_new),
    .chg_pop(chg_pop), .exp_pop(exp_pop), .run(exp_run), .hold2(hold2),
    .exp_full(exp_full), .exp_second(exp_second), .exp_ival(exp_ival),
    .exp_ovf(exp_ovf)
  );

  pix_evt_port #(
    .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W), .X_ADDR(X_ADDR), .Y_ADDR(Y_ADDR)
  ) u_port (
    .clk(clk), .rst(rst), .chg_full(chg_full), .chg_pol(chg_pol),
    .exp_full(exp_full), .exp_second(exp_second), .exp_ival(exp_ival),
    .exp_ovf(exp_ovf), .ack(ack), .req(req), .evt_word(evt_word),
    .evt_exp(evt_exp), .evt_ival(evt_ival), .evt_ovf(evt_ovf),
    .chg_pop(chg_pop), .exp_pop(exp_pop)
  );

  assign cd_rst = chg_full;
endmodule

// File: tb/sim_pix_evt_seq.sv
module sim_pix_evt_seq;
  localparam int X_W = 9, Y_W = 8, CNT_W = 8;
  localparam int XA = 300, YA = 201;
  localparam int MAXV = (1 << CNT_W) - 1;
  localparam int W = X_W + Y_W + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic chg_up = 0, chg_dn = 0, thr1 = 0, thr2 = 0, ack = 0;
  logic req, evt_exp, evt_ovf, cd_rst, exp_run;
  logic [W-1:0] evt_word;
  logic [CNT_W-1:0] evt_ival;

  always #4 clk = ~clk;

  pix_evt_seq #(.X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W), .X_ADDR(XA), .Y_ADDR(YA)) u0 (
    .clk(clk), .rst(rst), .chg_up(chg_up), .chg_dn(chg_dn), .thr1(thr1),
    .thr2(thr2), .ack(ack), .req(req), .evt_word(evt_word), .evt_exp(evt_exp),
    .evt_ival(evt_ival), .evt_ovf(evt_ovf), .cd_rst(cd_rst), .exp_run(exp_run)
  );

  int nchk = 0, nbad = 0;
  int ack_dly = 1, rel_dly = 0;
  int log_n = 0;
  int lg_e[0:15], lg_b0[0:15], lg_iv[0:15], lg_ov[0:15], lg_w[0:15], lg_st[0:15];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int want_ival(input int d);
    return (d > MAXV) ? MAXV : d;
  endfunction

  function automatic int want_ovf(input int d, input bit t2);
    return (!t2 || d > MAXV) ? 1 : 0;
  endfunction

  // four-phase responder and event logger
  initial begin
    int wcnt = 0, rcnt = 0, unst = 0, waiting = 0, held = 0;
    forever begin
      @(negedge clk);
      if (req && !ack) begin
        if (waiting && int'(evt_word) != held) unst = 1;
        held = int'(evt_word);
        waiting = 1;
        if (wcnt >= ack_dly) begin
          ack = 1'b1;
          wcnt = 0;
          if (log_n < 16) begin
            lg_e[log_n] = int'(evt_exp);
            lg_b0[log_n] = int'(evt_word[0]);
            lg_iv[log_n] = int'(evt_ival);
            lg_ov[log_n] = int'(evt_ovf);
            lg_w[log_n] = int'(evt_word);
            lg_st[log_n] = !unst;
          end
          log_n++;
          unst = 0;
          waiting = 0;
          @(negedge clk);
          check(req == 1'b0, "R8 req drop after ack", int'(req), 0);
        end else wcnt++;
      end else if (!req && ack) begin
        if (rcnt >= rel_dly) begin
          ack = 1'b0;
          rcnt = 0;
        end else rcnt++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; chg_up = 0; chg_dn = 0; thr1 = 0; thr2 = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    log_n = 0;
  endtask

  task automatic wait_ev(input int n);
    for (int k = 0; k < 3000 && log_n < n; k++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_chg(input bit up);
    @(negedge clk);
    if (up) chg_up = 1; else chg_dn = 1;
    @(negedge clk);
    chg_up = 0; chg_dn = 0;
  endtask

  task automatic wait_run();
    for (int k = 0; k < 500 && !exp_run; k++) @(negedge clk);
  endtask

  task automatic chk_ev(input int i, input int e, input int b0, input int iv, input int ov,
                        input string tag);
    int act, expv;
    expv = (e << 20) | (b0 << 19) | (ov << 18) | iv;
    act = (i < log_n && i < 16) ? ((lg_e[i] << 20) | (lg_b0[i] << 19) | (lg_ov[i] << 18) | lg_iv[i]) : -1;
    check(act == expv, tag, act, expv);
    if (i < log_n && i < 16) check(lg_st[i] == 1, "R8 word stable while waiting", lg_st[i], 1);
  endtask

  // one full change + measurement; thr2 after d edges when t2
  task automatic run_meas(input bit up, input int d, input bit t2, input string tag);
    pulse_chg(up);
    wait_run();
    thr1 = 1;
    repeat (d) @(negedge clk);
    if (t2) thr2 = 1;
    wait_ev(3);
    thr1 = 0; thr2 = 0;
    check(log_n == 3, {tag, " event count"}, log_n, 3);
    chk_ev(0, 0, int'(up), 0, 0, {tag, " R2 change event"});
    chk_ev(1, 1, 0, 0, 0, {tag, " R5 first exposure"});
    chk_ev(2, 1, 1, want_ival(d), want_ovf(d, t2), {tag, " R5 second exposure"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset values
    check({req, cd_rst, exp_run, evt_exp, evt_ovf} == 5'b0, "R1 control outputs", int'({req, cd_rst, exp_run, evt_exp, evt_ovf}), 0);
    check(evt_word == '0, "R1 word", int'(evt_word), 0);

    // R4 thresholds without change
    @(negedge clk); thr1 = 1;
    repeat (5) @(negedge clk); thr2 = 1;
    repeat (20) @(negedge clk);
    thr1 = 0; thr2 = 0;
    check(log_n == 0 && req == 0, "R4 no output without change", log_n, 0);

    // R2 R5 R10 directed
    do_reset(); ack_dly = 1; rel_dly = 0;
    run_meas(1'b1, 5, 1'b1, "dir up");
    check(lg_w[0] >> (Y_W + 1) == XA, "R10 column field", lg_w[0] >> (Y_W + 1), XA);
    check(((lg_w[0] >> 1) & ((1 << Y_W) - 1)) == YA, "R10 row field", (lg_w[0] >> 1) & ((1 << Y_W) - 1), YA);
    do_reset();
    run_meas(1'b0, 1, 1'b1, "dir down d1");

    // R3 detector held in reset until ack
    do_reset(); ack_dly = 10;
    @(negedge clk); chg_dn = 1;
    repeat (6) @(negedge clk);
    check(cd_rst == 1, "R3 cd_rst high while pending", int'(cd_rst), 1);
    chg_dn = 0;
    wait_ev(1);
    check(log_n == 1, "R3 one change event only", log_n, 1);
    check(cd_rst == 0, "R3 cd_rst low after ack", int'(cd_rst), 0);

    // R6 saturation
    do_reset(); ack_dly = 2;
    run_meas(1'b1, MAXV, 1'b1, "R6 exact max");
    do_reset();
    run_meas(1'b1, MAXV + 40, 1'b0, "R6 overflow");

    // R7 abort during measurement
    do_reset(); ack_dly = 1;
    pulse_chg(1'b1);
    wait_run();
    thr1 = 1;
    repeat (4) @(negedge clk);
    pulse_chg(1'b0);
    thr1 = 0;
    wait_run();
    thr1 = 1;
    repeat (7) @(negedge clk);
    thr2 = 1;
    wait_ev(5);
    thr1 = 0; thr2 = 0;
    check(log_n == 5, "R7 event count", log_n, 5);
    chk_ev(2, 0, 0, 0, 0, "R7 aborting change");
    chk_ev(3, 1, 0, 0, 0, "R7 restarted first exposure");
    chk_ev(4, 1, 1, 7, 0, "R7 restarted interval");

    // R9 priority with both holders full
    do_reset(); ack_dly = 6; rel_dly = 4;
    pulse_chg(1'b1);
    wait_run();
    thr1 = 1;
    repeat (3) @(negedge clk);
    thr2 = 1;
    @(negedge clk);
    chg_dn = 1;
    for (int k = 0; k < 200 && !cd_rst; k++) @(negedge clk);
    chg_dn = 0; thr1 = 0; thr2 = 0;
    wait_ev(4);
    check(log_n == 4, "R9 event count", log_n, 4);
    chk_ev(1, 1, 0, 0, 0, "R9 first exposure");
    chk_ev(2, 0, 0, 0, 0, "R9 change goes first");
    chk_ev(3, 1, 1, 3, 0, "R9 held interval delivered");

    // randomized trials
    for (int t = 0; t < 10; t++) begin
      int d;
      bit up;
      do_reset();
      up = 1'($urandom % 2);
      d = 1 + int'($urandom % 200);
      ack_dly = int'($urandom % 5);
      rel_dly = int'($urandom % 3);
      run_meas(up, d, 1'b1, "rand");
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule